// File: doc/BRIEF.md
# Software Interrupt and Tick Compare Unit

This block keeps a 16-bit pending-interrupt word that privileged software fills in to post deferred work to itself. Setting bit n of the word (n from 1 to 15) requests an interrupt at level n. The block also runs a free-running tick counter beside a compare register. While the compare register is enabled and its compare field equals the counter, hardware sets bit 0 of the pending word, which is the timer flag. A priority encoder reports the highest pending level on `irq_lvl`. The timer flag counts as level 14.

Software reaches the block through a single-cycle register port. The port has four selectors: a direct load of the pending word, a set alias that ORs data into the word, a clear alias that clears the bits given as ones, and the compare register. Every request gets a response on the next cycle. A privileged request gets an acknowledge. An unprivileged request gets a trap request and changes nothing.

The response stage is a three-state machine: `RSP_IDLE`, `RSP_ACK` and `RSP_TRAP`. From any state, the next state is `RSP_ACK` when a privileged request is present, `RSP_TRAP` when an unprivileged request is present, and `RSP_IDLE` when there is no request. Back-to-back requests therefore move directly between `RSP_ACK` and `RSP_TRAP`.

Top module: `swi_tick_unit`

## Requirements
- R1: After reset, the pending word is zero and `irq_lvl` is 0. The compare register reads as disable bit set (bit CNT_W) and field zero. `ack` and `trap` are low.
- R2: A privileged write with `addr`=0 loads `wdata[15:0]` into the pending word.
- R3: A privileged write with `addr`=1 ORs `wdata[15:0]` into the pending word.
- R4: A privileged write with `addr`=2 clears each pending bit whose `wdata` bit is one and leaves the other bits unchanged.
- R5: `irq_lvl` equals the index of the highest set pending bit among 15..1. It is 0 when the pending word is zero.
- R6: Pending bit 0 (the timer flag) is encoded as level 14. Bit 15 therefore still outranks it.
- R7: When the compare disable bit is clear, bit 0 is set at the clock edge where the counter equals the compare field. `irq_lvl` shows it one cycle after the counter holds that value.
- R8: While the disable bit is set, no counter value ever sets bit 0.
- R9: Once set, the timer flag stays set until software clears it, even after the counter moves past the compare value.
- R10: When a match and a software clear of bit 0 fall on the same edge, bit 0 ends up set.
- R11: An unprivileged request to any selector raises `trap` for one cycle on the next cycle and returns zero data. It leaves the pending word and the compare register unchanged, and `ack` stays low.
- R12: A privileged request raises `ack` for one cycle on the next cycle. `rdata` holds the value before the access: the zero-extended pending word for `addr` 0, 1 or 2, and the compare register (disable bit at CNT_W, field below it) for `addr`=3.
- R13: The tick counter starts at zero on reset, advances by one every cycle, and wraps modulo 2^CNT_W. A compare value that has already gone by therefore matches after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Register access request, single cycle |
| we | input | 1 | Write when high, read when low |
| priv | input | 1 | Requester is privileged |
| addr | input | 2 | Selector: 0 pending, 1 set alias, 2 clear alias, 3 compare |
| wdata | input | DATA_W | Write data |
| ack | output | 1 | Privileged access completed (next cycle) |
| trap | output | 1 | Privileged-operation trap request (next cycle) |
| rdata | output | DATA_W | Value before the access, valid with ack |
| irq_lvl | output | LVL_W | Highest pending interrupt level, 0 if none |

## Verification
The bench builds the unit with CNT_W=8 and keeps the default 16 levels with the timer flag at level 14. With these values the counter wraps every 256 cycles, so the bench can reach a compare value that was already passed. It can also leave a set timer flag in place across a full counter period and watch the flag survive the next match. The 9-bit compare word puts the disable bit at bit 8. This lets the bench place a software clear on the exact edge where the counter equals the compare field.

// File: rtl/swi_pkg.sv
package swi_pkg;

    // Register selector decoded from the access address
    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_SET  = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_CMP  = 2'd3
    } reg_sel_e;

    // Response state of the register port
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_ACK  = 2'd1,
        RSP_TRAP = 2'd2
    } rsp_state_e;

    // Software operation applied to the pending word this cycle
    typedef enum logic [1:0] {
        PW_HOLD = 2'd0,
        PW_LOAD = 2'd1,
        PW_SET  = 2'd2,
        PW_CLR  = 2'd3
    } pend_op_e;

endpackage

// File: rtl/swi_tick_counter.sv
module swi_tick_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    // Free-running; wraps naturally at 2^CNT_W
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/swi_cmp_match.sv
module swi_cmp_match #(
    parameter int CNT_W = 63,
    localparam int CW   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_word,
    input  logic [CNT_W-1:0] cnt,
    output logic [CW-1:0]    cmp_word,
    output logic             cmp_dis,
    output logic             match
);

    logic [CW-1:0] cmp_q;

    // Disable bit sits at the top; reset leaves the compare disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= {1'b1, {CNT_W{1'b0}}};
        end else if (wr_en) begin
            cmp_q <= wr_word;
        end
    end

    assign cmp_word = cmp_q;
    assign cmp_dis  = cmp_q[CNT_W];
    assign match    = !cmp_q[CNT_W] && (cmp_q[CNT_W-1:0] == cnt);

endmodule

// File: rtl/swi_pend_reg.sv
module swi_pend_reg
    import swi_pkg::*;
#(
    parameter int LEVELS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pend_op_e          op,
    input  logic [LEVELS-1:0] wr_bits,
    input  logic              hw_set0,
    output logic [LEVELS-1:0] pend
);

    logic [LEVELS-1:0] pend_q;
    logic [LEVELS-1:0] sw_next;
    logic [LEVELS-1:0] pend_d;

    always_comb begin
        unique case (op)
            PW_LOAD: sw_next = wr_bits;
            PW_SET:  sw_next = pend_q | wr_bits;
            PW_CLR:  sw_next = pend_q & ~wr_bits;
            default: sw_next = pend_q;
        endcase
        // hardware timer set is applied last so it beats any software clear
        pend_d    = sw_next;
        pend_d[0] = sw_next[0] | hw_set0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/swi_prio_enc.sv
module swi_prio_enc #(
    parameter int LEVELS    = 16,
    parameter int TIMER_LVL = 14,
    localparam int LVL_W    = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] pend,
    output logic [LVL_W-1:0]  lvl
);

    logic [LEVELS-1:0] lvl_req;

    // Fold the timer flag into its assigned level
    assign lvl_req[0] = 1'b0;
    for (genvar g = 1; g < LEVELS; g++) begin : g_req
        if (g == TIMER_LVL) begin : g_tmr
            assign lvl_req[g] = pend[g] | pend[0];
        end else begin : g_plain
            assign lvl_req[g] = pend[g];
        end
    end

    always_comb begin
        lvl = '0;
        for (int i = 1; i < LEVELS; i++) begin
            if (lvl_req[i]) begin
                lvl = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/swi_tick_unit.sv
module swi_tick_unit
    import swi_pkg::*;
#(
    parameter int LEVELS    = 16,
    parameter int CNT_W     = 63,
    parameter int DATA_W    = 64,
    parameter int TIMER_LVL = 14,
    localparam int LVL_W    = $clog2(LEVELS),
    localparam int CW       = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              priv,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              trap,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  irq_lvl
);

    reg_sel_e          sel;
    rsp_state_e        state_q;
    rsp_state_e        state_d;
    pend_op_e          pend_op;
    logic              acc_ok;
    logic              wr_ok;
    logic              cmp_wr;
    logic [CNT_W-1:0]  cnt;
    logic [CW-1:0]     cmp_word;
    logic              cmp_dis;
    logic              match_hit;
    logic [LEVELS-1:0] pend_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign sel    = reg_sel_e'(addr);
    assign acc_ok = req && priv;
    assign wr_ok  = acc_ok && we;
    assign cmp_wr = wr_ok && (sel == SEL_CMP);

    if (DATA_W > CW) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^wdata[DATA_W-1:CW];
    end

    always_comb begin
        pend_op = PW_HOLD;
        if (wr_ok) begin
            unique case (sel)
                SEL_PEND: pend_op = PW_LOAD;
                SEL_SET:  pend_op = PW_SET;
                SEL_CLR:  pend_op = PW_CLR;
                default:  pend_op = PW_HOLD;
            endcase
        end
    end

    swi_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    swi_cmp_match #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmp_wr),
        .wr_word  (wdata[CW-1:0]),
        .cnt      (cnt),
        .cmp_word (cmp_word),
        .cmp_dis  (cmp_dis),
        .match    (match_hit)
    );

    swi_pend_reg #(.LEVELS(LEVELS)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (pend_op),
        .wr_bits (wdata[LEVELS-1:0]),
        .hw_set0 (match_hit),
        .pend    (pend_q)
    );

    swi_prio_enc #(.LEVELS(LEVELS), .TIMER_LVL(TIMER_LVL)) u_enc (
        .pend (pend_q),
        .lvl  (irq_lvl)
    );

    // Response state machine: next state follows the current request
    always_comb begin
        state_d = RSP_IDLE;
        if (req) begin
            state_d = priv ? RSP_ACK : RSP_TRAP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ack  = 1'b0;
        trap = 1'b0;
        unique case (state_q)
            RSP_IDLE: begin
                ack  = 1'b0;
                trap = 1'b0;
            end
            RSP_ACK:  ack  = 1'b1;
            RSP_TRAP: trap = 1'b1;
            default: begin
                ack  = 1'b0;
                trap = 1'b0;
            end
        endcase
    end

    // Read data: value held before this access
    always_comb begin
        if (sel == SEL_CMP) begin
            rd_mux = DATA_W'(cmp_word);
        end else begin
            rd_mux = DATA_W'(pend_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= acc_ok ? rd_mux : '0;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/swi_tick_unit_chk.sv
module swi_tick_unit_chk #(
    parameter int LEVELS = 16,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic              priv,
    input logic              ack,
    input logic              trap,
    input logic [LVL_W-1:0]  irq_lvl,
    input logic [LEVELS-1:0] pend,
    input logic              cmp_dis,
    input logic              match
);

    a_r11_trap_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !priv) |=> (trap && !ack));

    a_r12_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req && priv) |=> (ack && !trap));

    a_r1_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!ack && !trap));

    a_r11_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !priv && !match) |=> $stable(pend));

    a_r7_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> pend[0]);

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_dis && !pend[0] && !(req && priv && we)) |=> !pend[0]);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !(req && priv && we)) |=> pend[0]);

    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (irq_lvl == '0));

endmodule

bind swi_tick_unit swi_tick_unit_chk #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .priv    (priv),
    .ack     (ack),
    .trap    (trap),
    .irq_lvl (irq_lvl),
    .pend    (pend_q),
    .cmp_dis (cmp_dis),
    .match   (match_hit)
);

// File: tb/sim_swi_tick_unit.sv
`timescale 1ns/1ps
module sim_swi_tick_unit;

    localparam int CNT_W  = 8;
    localparam int LEVELS = 16;
    localparam int DATA_W = 64;
    localparam int LVL_W  = 4;
    localparam int NVEC   = 13;

    // fields: addr[43:42] we[41] priv[40] wdata[39:24] exp_rdata[23:8] exp_lvl[7:4] req_no[3:0]
    localparam logic [43:0] VECS [NVEC] = '{
        {2'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 4'd0,  4'd12}, // R12 read after reset
        {2'd0, 1'b1, 1'b1, 16'h0006, 16'h0000, 4'd2,  4'd2},  // R2 direct load
        {2'd1, 1'b1, 1'b1, 16'h0100, 16'h0006, 4'd8,  4'd3},  // R3 set alias
        {2'd2, 1'b1, 1'b1, 16'h0104, 16'h0106, 4'd1,  4'd4},  // R4 clear alias
        {2'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 4'd1,  4'd11}, // R11 unprivileged load
        {2'd1, 1'b1, 1'b1, 16'h0001, 16'h0002, 4'd14, 4'd6},  // R6 timer flag as 14
        {2'd1, 1'b1, 1'b1, 16'h8000, 16'h0003, 4'd15, 4'd5},  // R5 top level wins
        {2'd2, 1'b1, 1'b1, 16'h8000, 16'h8003, 4'd14, 4'd6},  // R6 back to flag
        {2'd2, 1'b1, 1'b1, 16'h0001, 16'h0003, 4'd1,  4'd4},  // R4 clear flag only
        {2'd1, 1'b0, 1'b1, 16'h0000, 16'h0002, 4'd1,  4'd12}, // R12 read via alias
        {2'd2, 1'b1, 1'b0, 16'h0002, 16'h0000, 4'd1,  4'd11}, // R11 unprivileged clear
        {2'd0, 1'b1, 1'b1, 16'h4000, 16'h0002, 4'd14, 4'd5},  // R5 single level
        {2'd0, 1'b1, 1'b1, 16'h0000, 16'h4000, 4'd0,  4'd2}   // R2 load zero
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic              priv = 1'b0;
    logic [1:0]        addr = 2'd0;
    logic [DATA_W-1:0] wdata = '0;
    logic              ack;
    logic              trap;
    logic [DATA_W-1:0] rdata;
    logic [LVL_W-1:0]  irq_lvl;
    logic [CNT_W-1:0]  cyc;
    int                n_run = 0;
    int                n_fail = 0;
    bit                finished = 1'b0;

    always #10 clk = ~clk;

    // bench model of the tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 8'd1;
    end

    swi_tick_unit #(.LEVELS(LEVELS), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .priv(priv), .addr(addr),
        .wdata(wdata), .ack(ack), .trap(trap), .rdata(rdata), .irq_lvl(irq_lvl)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the capturing edge
    task automatic access(input logic [1:0] a, input logic w, input logic p, input logic [63:0] d);
        req = 1'b1; we = w; priv = p; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0; priv = 1'b0; wdata = '0;
    endtask

    task automatic wait_cyc(input logic [CNT_W-1:0] t);
        while (cyc != t) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ack", 64'(ack), 64'd0);
        chk("R1 trap", 64'(trap), 64'd0);
        chk("R1 lvl", 64'(irq_lvl), 64'd0);
        access(2'd3, 1'b0, 1'b1, '0);
        chk("R1 compare reset word", rdata, 64'h100);

        for (int i = 0; i < NVEC; i++) begin
            logic [43:0] e;
            string t;
            e = VECS[i];
            t = $sformatf("R%0d vec%0d", e[3:0], i);
            access(e[43:42], e[41], e[40], 64'(e[39:24]));
            chk({t, " ack"}, 64'(ack), 64'(e[40]));
            chk({t, " trap"}, 64'(trap), 64'(!e[40]));
            chk({t, " rdata"}, rdata, 64'(e[23:8]));
            chk({t, " lvl"}, 64'(irq_lvl), 64'(e[7:4]));
        end

        // R7 exact match cycle, R12 compare readback
        v = cyc + 8'd30;
        access(2'd3, 1'b1, 1'b1, 64'(v));
        access(2'd3, 1'b0, 1'b1, '0);
        chk("R12 compare readback", rdata, 64'(v));
        wait_cyc(v);
        chk("R7 no flag before match", 64'(irq_lvl), 64'd0);
        @(negedge clk);
        chk("R7 flag after match", 64'(irq_lvl), 64'd14);

        // R9 flag holds across a full counter period
        repeat (300) @(negedge clk);
        chk("R9 flag sticky", 64'(irq_lvl), 64'd14);
        access(2'd2, 1'b1, 1'b1, 64'h1);
        chk("R4 clear timer flag", 64'(irq_lvl), 64'd0);

        // R8 disabled compare
        v = cyc + 8'd10;
        access(2'd3, 1'b1, 1'b1, 64'h100 | 64'(v));
        repeat (300) @(negedge clk);
        chk("R8 disabled lvl", 64'(irq_lvl), 64'd0);
        access(2'd0, 1'b0, 1'b1, '0);
        chk("R8 disabled pending", rdata, 64'd0);

        // R13 match reached only after the counter wraps
        v = cyc - 8'd2;
        access(2'd3, 1'b1, 1'b1, 64'(v));
        wait_cyc(v);
        chk("R13 no early match", 64'(irq_lvl), 64'd0);
        @(negedge clk);
        chk("R13 match after wrap", 64'(irq_lvl), 64'd14);

        // R10 clear and match on the same edge
        v = cyc + 8'd20;
        access(2'd3, 1'b1, 1'b1, 64'(v));
        wait_cyc(v);
        access(2'd2, 1'b1, 1'b1, 64'h1);
        chk("R10 ack", 64'(ack), 64'd1);
        chk("R10 set wins", 64'(irq_lvl), 64'd14);
        access(2'd2, 1'b1, 1'b1, 64'h1);
        chk("R10 later clear works", 64'(irq_lvl), 64'd0);

        // R11 unprivileged compare write leaves compare intact
        access(2'd3, 1'b1, 1'b0, 64'h1FF);
        chk("R11 compare trap", 64'(trap), 64'd1);
        chk("R11 compare no ack", 64'(ack), 64'd0);
        access(2'd3, 1'b0, 1'b1, '0);
        chk("R11 compare unchanged", rdata, 64'(v));
        @(negedge clk);
        chk("R1 idle after access", 64'(ack | trap), 64'd0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule